// File: doc/BRIEF.md
# I2C Master SCL Clock Generator with Stretch Support

This block produces the serial clock of an I2C master on an open-drain, wired-AND line. It never drives the line high. It enables a pull-down for the programmed low time and then releases the line. It times the high phase only after the line, read back through a synchroniser, is really seen high. Any other device can therefore hold the clock low to slow each bit or to stall the bus after a byte and its acknowledge. If another device pulls the line low during the high phase, the block restarts its low phase at once, so that it follows the earliest falling edge on the bus.

Two one-cycle strobes mark the start of each low phase and the first sampled high level. A byte shifter uses one strobe to change SDA and the other to sample it. A configuration bit decides whether a low-power wait request stops clock generation and abandons the transfer. A stop request freezes the whole block in place.

States: IDLE (line released, waiting for enable), LOW (pull-down on, counting the low period), RELEASE (pull-down off, waiting for the line to read high), HIGH (counting the high period while watching for an external low), ABORT (one cycle that drops a transfer cut off by wait mode). Transitions: IDLE→LOW on enable with no wait gate. LOW→RELEASE when the low count ends. RELEASE→HIGH when the settled synchronised level is high. HIGH→LOW when the line is seen low (synchronisation) or when the high count ends with enable set. HIGH→IDLE when the high count ends with enable clear. LOW/RELEASE/HIGH→ABORT under the wait gate. ABORT→IDLE.

Top module: `scl_gen`

## Requirements
- R1: After reset the pull-down is off, busy is low and both strobes are low.
- R2: With no other device on the line, consecutive falling strobes are low_cnt + SYNC_STAGES + 1 + high_cnt cycles apart. The pull-down is on for low_cnt cycles of that period, and a count of 0 acts as 1.
- R3: If the line is held low past the programmed low time, no rising strobe appears while it is held. The rising strobe comes SYNC_STAGES + 1 cycles after the line is released.
- R4: An external low during the high phase starts a new low phase. The falling strobe appears SYNC_STAGES + 1 cycles after the line goes low, before the high count ends.
- R5: If a device holds the line low after the ninth falling strobe, the block waits for any length of time with busy high and no rising strobe, then resumes normally.
- R6: With wait_stop_en = 1, a wait request releases the line and clears busy on the next cycle. No strobes occur while the request stays high. Once it drops, a new low phase starts on the next cycle if enable is set.
- R7: With wait_stop_en = 0, a wait request has no effect on the clock period.
- R8: While stop_req is high, the pull-down and busy hold their values and no strobe is produced. Operation continues after stop_req drops.
- R9: When enable drops, the current bit completes. The block then goes idle with busy low and the line released, and produces no further falling strobes.
- R10: Each strobe lasts exactly one cycle, and the two strobes never occur together. The falling strobe occurs only while pulling down, and the rising strobe only while released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run clock generation |
| low_cnt | input | CW | Low period in clock cycles |
| high_cnt | input | CW | High period in clock cycles |
| wait_req | input | 1 | Low-power wait indication |
| wait_stop_en | input | 1 | 1: stop and abort while in wait |
| stop_req | input | 1 | Stop mode: freeze all state |
| scl_in | input | 1 | Raw SCL bus level |
| scl_pd | output | 1 | Pull-down enable for SCL |
| fall_stb | output | 1 | One-cycle strobe at the start of a low phase |
| rise_stb | output | 1 | One-cycle strobe at the first sampled high |
| busy | output | 1 | Transfer in progress |

## Verification
The bench uses the default CW = 16 and SYNC_STAGES = 2, so the latency from release to rising strobe and from external low to falling strobe is three cycles. That latency is short enough to measure exactly. Random low and high counts from 1 to 12 keep each period short, so many periods fit in the run. Directed holds of several hundred cycles exercise unbounded stretching, and the short counts make the resync case reachable in the middle of the high phase.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;
    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_LOW   = 3'd1,
        S_REL   = 3'd2,
        S_HIGH  = 3'd3,
        S_ABORT = 3'd4
    } scl_state_t;
endpackage

// File: rtl/scl_sync.sv
module scl_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] pipe;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe <= '1;
                else        pipe <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe <= '1;
                else        pipe <= {pipe[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/scl_phase_cnt.sv
module scl_phase_cnt #(
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] cnt
);
    localparam logic [CW-1:0] CMAX = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (run) begin
            if (clr)                     cnt <= '0;
            else if (inc && cnt != CMAX) cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/scl_fsm.sv
module scl_fsm
    import scl_gen_pkg::*;
#(
    parameter int unsigned CW     = 16,
    parameter int unsigned STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          gate,
    input  logic          enable,
    input  logic [CW-1:0] low_cnt,
    input  logic [CW-1:0] high_cnt,
    input  logic          scl_s,
    input  logic [CW-1:0] cnt,
    output logic          cnt_clr,
    output logic          cnt_inc,
    output logic          scl_pd,
    output logic          busy,
    output logic          fall_stb,
    output logic          rise_stb
);
    localparam logic [CW-1:0] SETTLE = CW'(STAGES);

    scl_state_t state_q, state_d;
    logic [CW:0] cnt_nx;
    logic        low_done, high_done, settled;
    logic        fall_q, rise_q;

    assign cnt_nx    = {1'b0, cnt} + 1'b1;
    assign low_done  = cnt_nx >= {1'b0, low_cnt};
    assign high_done = cnt_nx >= {1'b0, high_cnt};
    assign settled   = cnt >= SETTLE;

    always_comb begin
        state_d = state_q;
        cnt_clr = 1'b0;
        cnt_inc = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (enable && !gate) begin
                    state_d = S_LOW;
                    cnt_clr = 1'b1;
                end
            end
            S_LOW: begin
                if (gate) begin
                    state_d = S_ABORT;
                    cnt_clr = 1'b1;
                end else if (low_done) begin
                    state_d = S_REL;
                    cnt_clr = 1'b1;
                end else begin
                    cnt_inc = 1'b1;
                end
            end
            S_REL: begin
                if (gate) begin
                    state_d = S_ABORT;
                    cnt_clr = 1'b1;
                end else if (settled && scl_s) begin
                    state_d = S_HIGH;
                    cnt_clr = 1'b1;
                end else if (!settled) begin
                    cnt_inc = 1'b1;
                end
            end
            S_HIGH: begin
                if (gate) begin
                    state_d = S_ABORT;
                    cnt_clr = 1'b1;
                end else if (!scl_s) begin
                    state_d = S_LOW;
                    cnt_clr = 1'b1;
                end else if (high_done) begin
                    state_d = enable ? S_LOW : S_IDLE;
                    cnt_clr = 1'b1;
                end else begin
                    cnt_inc = 1'b1;
                end
            end
            S_ABORT: begin
                state_d = S_IDLE;
                cnt_clr = 1'b1;
            end
            default: begin
                state_d = S_IDLE;
                cnt_clr = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            fall_q  <= 1'b0;
            rise_q  <= 1'b0;
        end else if (!run) begin
            fall_q  <= 1'b0;
            rise_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            fall_q  <= (state_d == S_LOW)  && (state_q != S_LOW);
            rise_q  <= (state_d == S_HIGH) && (state_q != S_HIGH);
        end
    end

    always_comb begin
        scl_pd   = (state_q == S_LOW);
        busy     = (state_q == S_LOW) || (state_q == S_REL) || (state_q == S_HIGH);
        fall_stb = fall_q;
        rise_stb = rise_q;
    end
endmodule

// File: rtl/scl_gen.sv
module scl_gen #(
    parameter int unsigned CW          = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic [CW-1:0] low_cnt,
    input  logic [CW-1:0] high_cnt,
    input  logic          wait_req,
    input  logic          wait_stop_en,
    input  logic          stop_req,
    input  logic          scl_in,
    output logic          scl_pd,
    output logic          fall_stb,
    output logic          rise_stb,
    output logic          busy
);
    logic          scl_s;
    logic          run, gate;
    logic          cnt_clr, cnt_inc;
    logic [CW-1:0] cnt;

    assign run  = !stop_req;
    assign gate = wait_req && wait_stop_en;

    scl_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (scl_in),
        .q     (scl_s)
    );

    scl_phase_cnt #(.CW(CW)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .cnt   (cnt)
    );

    scl_fsm #(.CW(CW), .STAGES(SYNC_STAGES)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .gate     (gate),
        .enable   (enable),
        .low_cnt  (low_cnt),
        .high_cnt (high_cnt),
        .scl_s    (scl_s),
        .cnt      (cnt),
        .cnt_clr  (cnt_clr),
        .cnt_inc  (cnt_inc),
        .scl_pd   (scl_pd),
        .busy     (busy),
        .fall_stb (fall_stb),
        .rise_stb (rise_stb)
    );
endmodule

// File: rtl/scl_gen_chk.sv
module scl_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic wait_req,
    input logic wait_stop_en,
    input logic stop_req,
    input logic scl_pd,
    input logic fall_stb,
    input logic rise_stb,
    input logic busy
);
    a_r10_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(fall_stb && rise_stb));

    a_r10_fall_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        fall_stb |=> !fall_stb);

    a_r10_rise_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rise_stb |=> !rise_stb);

    a_r10_fall_in_low: assert property (@(posedge clk) disable iff (!rst_n)
        fall_stb |-> scl_pd);

    a_r10_rise_released: assert property (@(posedge clk) disable iff (!rst_n)
        rise_stb |-> !scl_pd);

    a_r6_wait_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_req && wait_stop_en && !stop_req) |=> (!scl_pd && !busy));

    a_r8_stop_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req |=> ($stable(scl_pd) && $stable(busy) && !fall_stb && !rise_stb));
endmodule

bind scl_gen scl_gen_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wait_req     (wait_req),
    .wait_stop_en (wait_stop_en),
    .stop_req     (stop_req),
    .scl_pd       (scl_pd),
    .fall_stb     (fall_stb),
    .rise_stb     (rise_stb),
    .busy         (busy)
);

// File: tb/scl_gen_test.sv
module scl_gen_test;
    localparam int CW = 16;
    localparam int SYNC = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b0;
    logic [CW-1:0] low_cnt = 16'd4;
    logic [CW-1:0] high_cnt = 16'd5;
    logic          wait_req = 1'b0;
    logic          wait_stop_en = 1'b0;
    logic          stop_req = 1'b0;
    logic          ext_hold = 1'b0;
    logic          scl_bus;
    logic          scl_pd, fall_stb, rise_stb, busy;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    assign scl_bus = ~scl_pd & ~ext_hold;

    scl_gen #(.CW(CW), .SYNC_STAGES(SYNC)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (enable),
        .low_cnt      (low_cnt),
        .high_cnt     (high_cnt),
        .wait_req     (wait_req),
        .wait_stop_en (wait_stop_en),
        .stop_req     (stop_req),
        .scl_in       (scl_bus),
        .scl_pd       (scl_pd),
        .fall_stb     (fall_stb),
        .rise_stb     (rise_stb),
        .busy         (busy)
    );

    function automatic int exp_period(int l, int h);
        int le;
        le = (l == 0) ? 1 : l;
        return le + SYNC + 1 + h;
    endfunction

    function automatic int exp_latency();
        return SYNC + 1;
    endfunction

    task automatic check(string req, int act, int expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // counts negedges until the chosen strobe is seen (1 = fall, 0 = rise)
    task automatic wait_stb(bit want_fall, int limit, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!(want_fall ? fall_stb : rise_stb) && n < limit);
    endtask

    task automatic measure_period(output int per, output int lows);
        int n;
        wait_stb(1'b1, 200, n);
        per = 0;
        lows = 0;
        do begin
            if (scl_pd) lows++;
            @(negedge clk);
            per++;
        end while (!fall_stb && per < 200);
    endtask

    initial begin
        int n, per, lows, l, h, bad;
        void'($urandom(32'd4711));

        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 pd", int'(scl_pd), 0);
        check("R1 busy", int'(busy), 0);
        check("R1 strobes", int'(fall_stb | rise_stb), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 random periods, no other device
        for (int i = 0; i < 8; i++) begin
            enable = 1'b0;
            wait_stb(1'b0, 1, n);
            repeat (40) @(negedge clk);
            l = $urandom_range(12, 1);
            h = $urandom_range(12, 1);
            low_cnt = l[CW-1:0];
            high_cnt = h[CW-1:0];
            enable = 1'b1;
            measure_period(per, lows);
            check("R2 period", per, exp_period(l, h));
            check("R2 low time", lows, l);
        end

        // R2 zero low count acts as one
        enable = 1'b0;
        repeat (40) @(negedge clk);
        low_cnt = 16'd0;
        high_cnt = 16'd3;
        enable = 1'b1;
        measure_period(per, lows);
        check("R2 zero low", per, exp_period(0, 3));

        low_cnt = 16'd4;
        high_cnt = 16'd5;
        repeat (30) @(negedge clk);

        // R3 stretch of the low phase
        wait_stb(1'b1, 200, n);
        ext_hold = 1'b1;
        bad = 0;
        repeat (25) begin
            @(negedge clk);
            if (rise_stb) bad++;
        end
        check("R3 no rise while held", bad, 0);
        ext_hold = 1'b0;
        wait_stb(1'b0, 50, n);
        check("R3 release latency", n, exp_latency());

        // R4 resync on an external low in the high phase
        high_cnt = 16'd20;
        wait_stb(1'b0, 200, n);
        @(negedge clk);
        ext_hold = 1'b1;
        wait_stb(1'b1, 50, n);
        ext_hold = 1'b0;
        check("R4 resync latency", n, exp_latency());
        high_cnt = 16'd5;

        // R5 hold after the ninth bit
        enable = 1'b0;
        repeat (60) @(negedge clk);
        enable = 1'b1;
        for (int b = 0; b < 9; b++) wait_stb(1'b1, 200, n);
        ext_hold = 1'b1;
        bad = 0;
        repeat (300) begin
            @(negedge clk);
            if (rise_stb || !busy) bad++;
        end
        check("R5 stalled", bad, 0);
        ext_hold = 1'b0;
        wait_stb(1'b0, 50, n);
        check("R5 resume", n, exp_latency());
        measure_period(per, lows);
        check("R5 next period", per, exp_period(4, 5));

        // R7 wait with gating disabled
        wait_stop_en = 1'b0;
        wait_req = 1'b1;
        measure_period(per, lows);
        check("R7 period in wait", per, exp_period(4, 5));
        wait_req = 1'b0;

        // R6 wait with gating enabled
        wait_stb(1'b0, 200, n);
        wait_stop_en = 1'b1;
        wait_req = 1'b1;
        @(negedge clk);
        check("R6 pd after abort", int'(scl_pd), 0);
        check("R6 busy after abort", int'(busy), 0);
        bad = 0;
        repeat (50) begin
            @(negedge clk);
            if (fall_stb || rise_stb || busy || scl_pd) bad++;
        end
        check("R6 quiet in wait", bad, 0);
        wait_req = 1'b0;
        wait_stb(1'b1, 50, n);
        check("R6 restart", n, 1);
        wait_stop_en = 1'b0;

        // R8 stop freeze at several points
        for (int k = 0; k < 3; k++) begin
            int sp, sb;
            repeat ($urandom_range(9, 1)) @(negedge clk);
            stop_req = 1'b1;
            @(negedge clk);
            sp = int'(scl_pd);
            sb = int'(busy);
            bad = 0;
            repeat (40) begin
                @(negedge clk);
                if (int'(scl_pd) != sp || int'(busy) != sb || fall_stb || rise_stb) bad++;
            end
            check("R8 frozen", bad, 0);
            stop_req = 1'b0;
        end
        measure_period(per, lows);
        check("R8 resumed period", per, exp_period(4, 5));

        // R9 enable drop
        enable = 1'b0;
        repeat (30) @(negedge clk);
        check("R9 busy", int'(busy), 0);
        check("R9 pd", int'(scl_pd), 0);
        bad = 0;
        repeat (30) begin
            @(negedge clk);
            if (fall_stb) bad++;
        end
        check("R9 no fall", bad, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule